// File: doc/BRIEF.md
# Dual-Port RAM with Collision Busy and Mailbox Flags

A two-port synchronous memory with one clock. Each port, left and right, has its own enable, write enable, address and data. Either port can read or write any word in the same cycle as the other. When both enabled ports present the same address, a busy indication goes to exactly one of them, and a write from the busy port is discarded. Reads are never blocked.

A mode input selects how busy is sourced. In master mode the block arbitrates and drives its busy outputs. In slave mode the busy outputs stay low, and per-port busy inputs from an external arbiter decide which writes are discarded.

The two highest addresses also act as mailboxes between the ports. Each port has an interrupt flag that the other port raises by writing that port's mailbox word. The owning port lowers its flag by reading the same word. The address width is a parameter: 15 bits gives 32768 words of 36 bits. The default is smaller so the array stays light at elaboration.

Top module: `dpr_mbox_ram`

## Requirements
- R1: A read (enable high, write enable low) returns the addressed word on that port's read data one clock later. Read data holds its value in cycles without a read.
- R2: A busy output is high only while both ports are enabled with equal addresses, and at most one busy output is high at any time.
- R3: On a fresh collision, the left port wins and right busy rises in that same cycle. A collision is fresh when the previous cycle had none. The one exception is covered by R4.
- R4: On a fresh collision where only the right port presented that address with enable in the previous cycle, the right port wins and left busy rises. The winner then stays the same as long as the collision continues.
- R5: A write from a port whose effective busy is high leaves memory unchanged. That port's reads still proceed.
- R6: When the mode input is 0 (slave), both busy outputs are low. A high busy input discards that port's writes.
- R7: A completed left write to the top address (all ones) raises the right interrupt flag at the next clock. A discarded write does not raise it.
- R8: A right read of the top address lowers the right interrupt flag at the next clock. If a raising write happens in the same cycle, the flag stays raised.
- R9: A completed right write to the address one below the top (all ones except bit 0) raises the left interrupt flag. A left read of that address lowers it, and raising wins when both happen in the same cycle.
- R10: While reset is low, both read data outputs are zero, both interrupt flags are low and both busy outputs are low.
- R11: Writes to the two mailbox addresses are stored like any other word and can be read back.
- R12: A read that coincides with a write to the same address from the other port returns the contents from before that write.
- R13: When both ports complete writes to the same address in the same cycle, the left port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| master_sel | input | 1 | 1 = block arbitrates busy, 0 = busy comes from inputs |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left write enable |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data |
| l_busy_o | output | 1 | Left busy from internal arbitration |
| l_busy_i | input | 1 | Left busy from an external arbiter (slave mode) |
| l_irq | output | 1 | Left mailbox flag |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right write enable |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data |
| r_busy_o | output | 1 | Right busy from internal arbitration |
| r_busy_i | input | 1 | Right busy from an external arbiter (slave mode) |
| r_irq | output | 1 | Right mailbox flag |

## Verification
The properties assume that all inputs are known in every cycle after reset. They also assume the busy inputs matter only while the mode input is low, so that in master mode the busy outputs alone decide which writes are discarded. The stimulus changes inputs only on the falling clock edge. It draws addresses from a pool of four ordinary words plus both mailbox words, which makes collisions, ownership hand-offs and mailbox traffic frequent. In slave mode it toggles the busy inputs at random, and it changes the mode only at segment boundaries.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Decide which port keeps access to a contested word.
  function automatic owner_e pick_owner(input logic hit, input owner_e held,
                                        input logic l_stay, input logic r_stay);
    if (!hit) return OWN_NONE;
    if (held != OWN_NONE) return held;
    if (r_stay && !l_stay) return OWN_RIGHT;
    return OWN_LEFT;
  endfunction

endpackage

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           wr_en,
  input  logic [1:0]           rd_en,
  input  logic [1:0][AW-1:0]   addr,
  input  logic [1:0][DW-1:0]   wdata,
  output logic [1:0][DW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Port 0 (left) is applied last, so it wins a same-word double write.
  always_ff @(posedge clk) begin
    if (wr_en[1]) mem[addr[1]] <= wdata[1];
    if (wr_en[0]) mem[addr[0]] <= wdata[0];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (rd_en[p]) q <= mem[addr[p]];
    end
    assign rdata[p] = q;
  end
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce,
  input  logic [AW-1:0] l_addr,
  input  logic          r_ce,
  input  logic [AW-1:0] r_addr,
  output logic          hit,
  output logic          busy_l,
  output logic          busy_r
);
  logic          pl_ce, pr_ce;
  logic [AW-1:0] pl_addr, pr_addr;
  owner_e        owner_q, owner_d;
  logic          l_stay, r_stay;

  assign hit    = l_ce && r_ce && (l_addr == r_addr);
  assign l_stay = pl_ce && (pl_addr == l_addr);
  assign r_stay = pr_ce && (pr_addr == r_addr);

  always_comb owner_d = pick_owner(hit, owner_q, l_stay, r_stay);

  assign busy_l = (owner_d == OWN_RIGHT);
  assign busy_r = (owner_d == OWN_LEFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      pl_ce   <= 1'b0;
      pr_ce   <= 1'b0;
      pl_addr <= '0;
      pr_addr <= '0;
    end else begin
      owner_q <= owner_d;
      pl_ce   <= l_ce;
      pr_ce   <= r_ce;
      pl_addr <= l_addr;
      pr_addr <= r_addr;
    end
  end
endmodule

// File: rtl/dpr_mbox.sv
module dpr_mbox #(
  parameter int AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         wr_en,
  input  logic [1:0]         rd_en,
  input  logic [1:0][AW-1:0] addr,
  output logic [1:0]         irq
);
  localparam logic [AW-1:0] MB_HI = '1;
  localparam logic [AW-1:0] MB_LO = {{(AW-1){1'b1}}, 1'b0};

  // Flag s belongs to port s; the other port raises it.
  for (genvar s = 0; s < 2; s++) begin : g_flag
    localparam logic [AW-1:0] SPOT = (s == 0) ? MB_LO : MB_HI;
    logic q, raise, lower;
    assign raise = wr_en[1-s] && (addr[1-s] == SPOT);
    assign lower = rd_en[s] && (addr[s] == SPOT);
    always_ff @(posedge clk) begin
      if (!rst_n)     q <= 1'b0;
      else if (raise) q <= 1'b1;
      else if (lower) q <= 1'b0;
    end
    assign irq[s] = q;
  end
endmodule

// File: rtl/dpr_mbox_ram.sv
module dpr_mbox_ram #(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_sel,
  input  logic          l_ce,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_busy_o,
  input  logic          l_busy_i,
  output logic          l_irq,
  input  logic          r_ce,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_busy_o,
  input  logic          r_busy_i,
  output logic          r_irq
);
  function automatic logic gate_busy(input logic mst, input logic own, input logic ext);
    return mst ? own : ext;
  endfunction

  logic arb_hit, arb_busy_l, arb_busy_r;
  logic blk_l, blk_r;
  logic l_wr_en, r_wr_en, l_rd_en, r_rd_en;
  logic [1:0][DW-1:0] rd_bus;
  logic [1:0]         irq_bus;

  dpr_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_addr(l_addr), .r_ce(r_ce), .r_addr(r_addr),
    .hit(arb_hit), .busy_l(arb_busy_l), .busy_r(arb_busy_r)
  );

  assign blk_l   = gate_busy(master_sel, arb_busy_l, l_busy_i);
  assign blk_r   = gate_busy(master_sel, arb_busy_r, r_busy_i);
  assign l_wr_en = l_ce && l_we && !blk_l;
  assign r_wr_en = r_ce && r_we && !blk_r;
  assign l_rd_en = l_ce && !l_we;
  assign r_rd_en = r_ce && !r_we;

  assign l_busy_o = master_sel && arb_busy_l;
  assign r_busy_o = master_sel && arb_busy_r;

  dpr_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en({r_wr_en, l_wr_en}), .rd_en({r_rd_en, l_rd_en}),
    .addr({r_addr, l_addr}), .wdata({r_wdata, l_wdata}),
    .rdata(rd_bus)
  );

  dpr_mbox #(.AW(AW)) u_mbox (
    .clk(clk), .rst_n(rst_n),
    .wr_en({r_wr_en, l_wr_en}), .rd_en({r_rd_en, l_rd_en}),
    .addr({r_addr, l_addr}), .irq(irq_bus)
  );

  assign l_rdata = rd_bus[0];
  assign r_rdata = rd_bus[1];
  assign l_irq   = irq_bus[0];
  assign r_irq   = irq_bus[1];
endmodule

// File: rtl/dpr_mbox_chk.sv
module dpr_mbox_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_sel,
  input logic          l_ce,
  input logic          l_we,
  input logic [AW-1:0] l_addr,
  input logic          l_busy_o,
  input logic          l_busy_i,
  input logic          l_irq,
  input logic          l_wr_en,
  input logic          r_ce,
  input logic          r_we,
  input logic [AW-1:0] r_addr,
  input logic          r_busy_o,
  input logic          r_busy_i,
  input logic          r_irq,
  input logic          r_wr_en
);
  localparam logic [AW-1:0] MB_HI = '1;
  localparam logic [AW-1:0] MB_LO = {{(AW-1){1'b1}}, 1'b0};

  logic same;
  assign same = l_ce && r_ce && (l_addr == r_addr);

  a_r2_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_o || r_busy_o) |-> same);
  a_r2_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({l_busy_o, r_busy_o}));
  a_r3_fresh_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && same && !$past(same) && !$past(r_ce)) |-> r_busy_o);
  a_r4_holder_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && same && $past(same) && $past(master_sel) && $past(l_busy_o)) |-> l_busy_o);
  a_r5_left_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce && l_we && (l_busy_o || (!master_sel && l_busy_i))) |-> !l_wr_en);
  a_r5_right_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (r_ce && r_we && (r_busy_o || (!master_sel && r_busy_i))) |-> !r_wr_en);
  a_r6_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (!l_busy_o && !r_busy_o));
  a_r7_right_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr_en && l_addr == MB_HI) |=> r_irq);
  a_r8_right_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (r_ce && !r_we && r_addr == MB_HI && !(l_wr_en && l_addr == MB_HI)) |=> !r_irq);
  a_r9_left_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr_en && r_addr == MB_LO) |=> l_irq);
  a_r9_left_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce && !l_we && l_addr == MB_LO && !(r_wr_en && r_addr == MB_LO)) |=> !l_irq);
endmodule

bind dpr_mbox_ram dpr_mbox_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
  .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_busy_o(l_busy_o),
  .l_busy_i(l_busy_i), .l_irq(l_irq), .l_wr_en(l_wr_en),
  .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_busy_o(r_busy_o),
  .r_busy_i(r_busy_i), .r_irq(r_irq), .r_wr_en(r_wr_en)
);

// File: tb/dpr_mbox_ram_tb.sv
module dpr_mbox_ram_tb;
  localparam int AW = 10;
  localparam int DW = 36;
  localparam logic [AW-1:0] TOP = '1;
  localparam logic [AW-1:0] TOPM = TOP - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1;
  logic lce = 0, lwe = 0, lbi = 0, rce = 0, rwe = 0, rbi = 0;
  logic [AW-1:0] la = '0, ra = '0;
  logic [DW-1:0] lwd = '0, rwd = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_o, r_busy_o, l_irq, r_irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dpr_mbox_ram #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_sel(master),
    .l_ce(lce), .l_we(lwe), .l_addr(la), .l_wdata(lwd), .l_rdata(l_rdata),
    .l_busy_o(l_busy_o), .l_busy_i(lbi), .l_irq(l_irq),
    .r_ce(rce), .r_we(rwe), .r_addr(ra), .r_wdata(rwd), .r_rdata(r_rdata),
    .r_busy_o(r_busy_o), .r_busy_i(rbi), .r_irq(r_irq)
  );

  // Reference state
  logic [DW-1:0] mm [0:(1<<AW)-1];
  logic [DW-1:0] e_rl = '0, e_rr = '0;
  logic e_il = 0, e_ir = 0;
  logic pl_ce = 0, pr_ce = 0, p_hit = 0;
  logic [AW-1:0] pl_a = '0, pr_a = '0;
  int p_win = 0;
  logic bl_s = 0, br_s = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // 0 none, 1 left holds the word, 2 right holds it
  function automatic int winner(input logic hit, input logic lh, input logic rh);
    if (!hit) return 0;
    if (p_hit) return p_win;
    return (rh && !lh) ? 2 : 1;
  endfunction

  task automatic run_cycle();
    int w;
    logic hit, blkl, blkr, lw, rw;
    #1;
    hit = lce && rce && (la == ra);
    w = winner(hit, pl_ce && pl_a == la, pr_ce && pr_a == ra);
    bl_s = l_busy_o;
    br_s = r_busy_o;
    chk("R2", {63'd0, l_busy_o}, {63'd0, master && w == 2});
    chk("R2", {63'd0, r_busy_o}, {63'd0, master && w == 1});
    blkl = master ? (w == 2) : lbi;
    blkr = master ? (w == 1) : rbi;
    lw = lce && lwe && !blkl;
    rw = rce && rwe && !blkr;
    if (lce && !lwe) e_rl = mm[la];
    if (rce && !rwe) e_rr = mm[ra];
    if (rce && !rwe && ra == TOP) e_ir = 1'b0;
    if (lw && la == TOP) e_ir = 1'b1;
    if (lce && !lwe && la == TOPM) e_il = 1'b0;
    if (rw && ra == TOPM) e_il = 1'b1;
    @(posedge clk);
    if (rw) mm[ra] = rwd;
    if (lw) mm[la] = lwd;
    pl_ce = lce; pl_a = la; pr_ce = rce; pr_a = ra;
    p_hit = hit; p_win = w;
    @(negedge clk);
    chk("R1", {28'd0, l_rdata}, {28'd0, e_rl});
    chk("R1", {28'd0, r_rdata}, {28'd0, e_rr});
    chk("R9", {63'd0, l_irq}, {63'd0, e_il});
    chk("R7", {63'd0, r_irq}, {63'd0, e_ir});
  endtask

  task automatic setl(input logic c, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    lce = c; lwe = w; la = a; lwd = d;
  endtask
  task automatic setr(input logic c, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    rce = c; rwe = w; ra = a; rwd = d;
  endtask
  task automatic idle();
    setl(0, 0, '0, '0); setr(0, 0, '0, '0); run_cycle();
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL all: watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] rnd;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    // R10 reset values
    chk("R10", {28'd0, l_rdata}, 64'd0);
    chk("R10", {28'd0, r_rdata}, 64'd0);
    chk("R10", {62'd0, l_irq, r_irq}, 64'd0);
    chk("R10", {62'd0, l_busy_o, r_busy_o}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      setl(1, 1, AW'(i), DW'(36'h10 + i)); setr(0, 0, '0, '0); run_cycle();
    end
    idle();
    // R12: right reads while left writes the same word
    setl(1, 1, AW'(1), 36'hA1A1); setr(1, 0, AW'(1), '0); run_cycle();
    chk("R12", {28'd0, r_rdata}, 64'h11);
    chk("R3", {63'd0, br_s}, 64'd1);
    idle();
    // R5: fresh double write, right loses
    setl(1, 1, AW'(2), 36'hB0B0); setr(1, 1, AW'(2), 36'hC0C0); run_cycle();
    idle();
    setr(1, 0, AW'(2), '0); run_cycle();
    chk("R5", {28'd0, r_rdata}, 64'hB0B0);
    idle();
    // R4: right arrives first and keeps the word
    setr(1, 0, AW'(3), '0); run_cycle();
    setl(1, 1, AW'(3), 36'hD1D1); setr(1, 1, AW'(3), 36'hE2E2); run_cycle();
    chk("R4", {63'd0, bl_s}, 64'd1);
    run_cycle();
    chk("R4", {63'd0, bl_s}, 64'd1);
    setl(0, 0, '0, '0); setr(1, 0, AW'(3), '0); run_cycle();
    chk("R5", {28'd0, r_rdata}, 64'hE2E2);
    idle();
    // Mailboxes
    setl(1, 1, TOP, 36'h5A5A5); run_cycle();
    chk("R7", {63'd0, r_irq}, 64'd1);
    setl(0, 0, '0, '0); setr(1, 0, TOP, '0); run_cycle();
    chk("R11", {28'd0, r_rdata}, 64'h5A5A5);
    chk("R8", {63'd0, r_irq}, 64'd0);
    setr(1, 1, TOPM, 36'h7C7C7); run_cycle();
    chk("R9", {63'd0, l_irq}, 64'd1);
    setr(0, 0, '0, '0); setl(1, 0, TOPM, '0); run_cycle();
    chk("R11", {28'd0, l_rdata}, 64'h7C7C7);
    chk("R9", {63'd0, l_irq}, 64'd0);
    idle();
    // R8: raise and lower together, raise wins
    setl(1, 1, TOP, 36'h1); setr(1, 0, TOP, '0); run_cycle();
    chk("R8", {63'd0, r_irq}, 64'd1);
    setl(0, 0, '0, '0); run_cycle();
    chk("R8", {63'd0, r_irq}, 64'd0);
    // R7: a discarded left write must not raise the flag
    setl(1, 1, TOP, 36'h2); run_cycle();
    chk("R7", {63'd0, r_irq}, 64'd0);
    idle();
    // Slave mode
    master = 1'b0;
    setl(1, 1, AW'(0), 36'hF0F0); setr(1, 1, AW'(0), 36'h0F0F); run_cycle();
    chk("R6", {62'd0, bl_s, br_s}, 64'd0);
    setr(0, 0, '0, '0); setl(1, 0, AW'(0), '0); run_cycle();
    chk("R13", {28'd0, l_rdata}, 64'hF0F0);
    rbi = 1'b1; setl(0, 0, '0, '0); setr(1, 1, AW'(1), 36'h999); run_cycle();
    rbi = 1'b0; setr(1, 0, AW'(1), '0); run_cycle();
    chk("R6", {28'd0, r_rdata}, 64'hA1A1);
    master = 1'b1;
    idle();

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) master = ($urandom % 4) != 0;
      lbi = master ? 1'b0 : (($urandom % 4) == 0);
      rbi = master ? 1'b0 : (($urandom % 4) == 0);
      lce = ($urandom % 4) != 0;
      rce = ($urandom % 4) != 0;
      lwe = $urandom % 2;
      rwe = $urandom % 2;
      case ($urandom % 6)
        0, 1, 2, 3: la = AW'($urandom % 4);
        4: la = TOPM;
        default: la = TOP;
      endcase
      case ($urandom % 6)
        0, 1, 2, 3: ra = AW'($urandom % 4);
        4: ra = TOPM;
        default: ra = TOP;
      endcase
      rnd = {$urandom, $urandom}; lwd = rnd[DW-1:0];
      rnd = {$urandom, $urandom}; rwd = rnd[DW-1:0];
      run_cycle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule